// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Bank with Edge Status

This block is one bank of general-purpose I/O pins. Software controls it through a small set of byte-wide registers. For each pin it sets the direction, the output level, a polarity swap and a drive style, and it keeps a latch of input edges. The block produces the value and output enable for every pad, and it samples the pad inputs through a synchroniser.

A pin behaves as GPIO only when two things hold: the bank enable bit is set, and the pin's claim bit is clear. A claimed or disabled pin is released, reads as zero, and ignores writes and edges.

Register access uses a plain address/data strobe port. A write takes effect on the strobe edge. Read data is captured on the strobe edge and presented, together with `rd_valid`, in the following cycle.

The read path is a two-state machine:
- `ST_IDLE` means no read response is pending. A read strobe moves it to `ST_ACK`; no strobe keeps it in `ST_IDLE`.
- `ST_ACK` presents the captured word with `rd_valid` high. A new read strobe keeps it in `ST_ACK`; no strobe returns it to `ST_IDLE`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is an input (direction 0xFF), non-inverted (0x00) and open-drain (mode 0xFF), with status 0x00. The claim mask and the bank enable are 0, so `pad_oe` and `pad_o` are all zero.
- R2: In the direction register (index 0), a cleared bit makes the pin an output and a set bit makes it an input, with its output enable off.
- R3: Writing the data register (index 1) sets the output level of each active pin. Reading index 1 returns the synchronised pad input of each active pin, two clock edges after the pad changes.
- R4: A set bit in the inversion register (index 2) inverts that pin both ways: the driven level is the data bit XOR the inversion bit, and the readback is the input XOR the inversion bit.
- R5: In the mode register (index 4), a cleared bit selects push-pull: the output enable is on and `pad_o` carries the level. A set bit selects open-drain: `pad_o` is 0, and the output enable is on only when the level is 0.
- R6: Any change of an active pin's synchronised input sets its bit in the status register (index 3), one cycle after the change is seen.
- R7: Reading the status register clears it. An edge detected in the same cycle as that read stays latched, and it is not part of the returned value.
- R8: A set bit in the claim register (index 5) removes that pin from GPIO use. The pin has `pad_oe` and `pad_o` at 0 and reads 0 from data and status. Writes to its data, direction, inversion and mode bits are ignored, and so are its edges.
- R9: Bit 0 of the enable register (index 6) gates the whole bank. While it is clear, every pin behaves as claimed.
- R10: A read strobe is answered in the next cycle with `rd_valid` high and the captured word. Addresses 7 to 255 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register index |
| wr_stb | input | 1 | Write strobe, one cycle |
| rd_stb | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read response present |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pad_o | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |

## Verification
Two functions can fall in the same cycle: the clear caused by a status read, and the latch of a new edge. The bench sets a status bit on one pin and then toggles a second pin. It times the status read strobe to land on the exact edge where the second pin's change first registers as an edge. The read must return only the older bit, and the next read must return only the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        IDX_DIR    = 3'd0,
        IDX_DATA   = 3'd1,
        IDX_INV    = 3'd2,
        IDX_STAT   = 3'd3,
        IDX_MODE   = 3'd4,
        IDX_CLAIM  = 3'd5,
        IDX_ENABLE = 3'd6
    } reg_idx_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= raw;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] synced,
    input  logic [W-1:0] act,
    input  logic         clr,
    output logic [W-1:0] stat
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    assign hit = (synced ^ prev_q) & act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat   <= '0;
        end else begin
            prev_q <= synced;
            stat   <= ((clr ? '0 : stat) | hit) & act;
        end
    end

    // R6: a detected edge on an active pin is held in the next cycle
    p_edge_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) && (hit == act) |=> ((stat & $past(hit)) == $past(hit)));

    // R7: a clearing read with no coincident edge leaves status empty
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr && (hit == '0) |=> (stat == '0));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] act,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] od,
    input  logic [W-1:0] level,
    output logic [W-1:0] pad_o,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic drive_en;
        assign drive_en  = act[i] & ~dir[i];
        assign pad_oe[i] = drive_en & (od[i] ? ~level[i] : 1'b1);
        assign pad_o[i]  = drive_en & ~od[i] & level[i];
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pad_o,
    output logic [DATA_W-1:0] pad_oe
);
    localparam int IDX_W = 3;

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] dir_q, inv_q, mode_q, out_q, claim_q;
    logic              en_q;
    logic [DATA_W-1:0] act, synced, stat, level, rd_mux;
    logic              in_map, stat_clr;
    reg_idx_e          idx;

    assign in_map   = (addr[ADDR_W-1:IDX_W] == '0) && (addr[IDX_W-1:0] != 3'd7);
    assign idx      = reg_idx_e'(addr[IDX_W-1:0]);
    assign act      = en_q ? ~claim_q : '0;
    assign level    = out_q ^ inv_q;
    assign stat_clr = rd_stb && in_map && (idx == IDX_STAT);

    gpio_pin_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(synced));

    gpio_edge_latch #(.W(DATA_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .synced(synced), .act(act),
        .clr(stat_clr), .stat(stat));

    gpio_pad_drive #(.W(DATA_W)) u_pad (
        .act(act), .dir(dir_q), .od(mode_q), .level(level),
        .pad_o(pad_o), .pad_oe(pad_oe));

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                                input logic [DATA_W-1:0] new_v,
                                                input logic [DATA_W-1:0] m);
        return (new_v & m) | (old_v & ~m);
    endfunction

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            inv_q   <= '0;
            mode_q  <= '1;
            out_q   <= '0;
            claim_q <= '0;
            en_q    <= 1'b0;
        end else if (wr_stb && in_map) begin
            case (idx)
                IDX_DIR:    dir_q   <= merge(dir_q,  wdata, act);
                IDX_DATA:   out_q   <= merge(out_q,  wdata, act);
                IDX_INV:    inv_q   <= merge(inv_q,  wdata, act);
                IDX_MODE:   mode_q  <= merge(mode_q, wdata, act);
                IDX_CLAIM:  claim_q <= wdata;
                IDX_ENABLE: en_q    <= wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        if (in_map) begin
            case (idx)
                IDX_DIR:    rd_mux = dir_q;
                IDX_DATA:   rd_mux = (synced ^ inv_q) & act;
                IDX_INV:    rd_mux = inv_q;
                IDX_STAT:   rd_mux = stat & act;
                IDX_MODE:   rd_mux = mode_q;
                IDX_CLAIM:  rd_mux = claim_q;
                IDX_ENABLE: rd_mux = {{(DATA_W-1){1'b0}}, en_q};
                default:    rd_mux = '0;
            endcase
        end
    end

    // read response state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_stb ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = rd_stb ? ST_ACK : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_mux;
    end

    assign rd_valid = (state_q == ST_ACK);

    // R10: every read strobe is answered in the following cycle
    p_read_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R8/R9: a pin outside GPIO use never has its output enable on
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_o) & ~act) == '0);

    // R2: input pins never drive
    p_input_no_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    // R5: an open-drain pin never drives high
    p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_o & mode_q) == '0);
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_valid;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_o, pad_oe;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .pin_in(pin_in), .pad_o(pad_o), .pad_oe(pad_oe));

    // {dir, inv, mode, data, expected pad_o, expected pad_oe}
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'h00, 8'h00, 8'hA5, 8'hA5, 8'hFF},
        {8'h00, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hFF},
        {8'h00, 8'h00, 8'hFF, 8'hA5, 8'h00, 8'h5A},
        {8'hF0, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'h0F},
        {8'h00, 8'h0F, 8'hF0, 8'h33, 8'h0C, 8'hCF},
        {8'hAA, 8'h00, 8'h00, 8'hFF, 8'h55, 8'h55}
    };

    task automatic check(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic vld);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rdata; vld = rd_valid;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic vld;

        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        check("R1 pad_o after reset", pad_o, 8'h00);

        // R9: bank disabled, writes to pin registers ignored
        wr(8'd0, 8'h00);
        check("R9 disabled bank does not drive", pad_oe, 8'h00);

        wr(8'd6, 8'h01);
        rd(8'd0, v, vld);
        check("R1 direction reset", v, 8'hFF);
        check("R10 rd_valid after strobe", {7'd0, vld}, 8'h01);
        rd(8'd4, v, vld); check("R1 mode reset", v, 8'hFF);
        rd(8'd2, v, vld); check("R1 inversion reset", v, 8'h00);
        rd(8'd3, v, vld); check("R1 status reset", v, 8'h00);
        rd(8'd7, v, vld); check("R10 unmapped index 7", v, 8'h00);
        rd(8'h40, v, vld); check("R10 unmapped high address", v, 8'h00);
        idle(1);
        check("R10 rd_valid falls without strobe", {7'd0, rd_valid}, 8'h00);

        // table of output configurations: R2 R3 R4 R5
        for (int i = 0; i < 6; i++) begin
            wr(8'd0, VEC[i][47:40]);
            wr(8'd2, VEC[i][39:32]);
            wr(8'd4, VEC[i][31:24]);
            wr(8'd1, VEC[i][23:16]);
            check($sformatf("R2/R3/R4/R5 row %0d pad_o", i), pad_o, VEC[i][15:8]);
            check($sformatf("R2/R3/R4/R5 row %0d pad_oe", i), pad_oe, VEC[i][7:0]);
        end

        // input readback and edges
        wr(8'd0, 8'hFF);
        wr(8'd2, 8'h00);
        check("R2 all inputs release pads", pad_oe, 8'h00);
        @(negedge clk); pin_in = 8'h3C;
        idle(4);
        rd(8'd1, v, vld); check("R3 data readback", v, 8'h3C);
        wr(8'd2, 8'hFF);
        rd(8'd1, v, vld); check("R4 inverted readback", v, 8'hC3);
        rd(8'd3, v, vld); check("R6 status latched edges", v, 8'h3C);
        rd(8'd3, v, vld); check("R7 status cleared by read", v, 8'h00);

        // R7: edge coinciding with the clearing read
        @(negedge clk); pin_in = 8'hBC;
        idle(4);
        @(negedge clk); pin_in = 8'hBE;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 8'd3; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R7 read returns older edge only", rdata, 8'h80);
        rd(8'd3, v, vld); check("R7 coincident edge kept", v, 8'h02);

        // R8: claimed pins
        wr(8'd2, 8'h00);
        wr(8'd0, 8'h00);
        wr(8'd4, 8'h00);
        wr(8'd1, 8'hFF);
        check("R5 push-pull all high", pad_o, 8'hFF);
        wr(8'd5, 8'h0F);
        check("R8 claimed pins released oe", pad_oe, 8'hF0);
        check("R8 claimed pins pad_o", pad_o, 8'hF0);
        wr(8'd1, 8'h00);
        check("R8 write reaches free pins", pad_o, 8'h00);
        wr(8'd5, 8'h00);
        check("R8 write ignored on claimed pins", pad_o, 8'h0F);
        wr(8'd0, 8'hFF);
        wr(8'd5, 8'h0F);
        @(negedge clk); pin_in = 8'hB1;
        idle(4);
        rd(8'd3, v, vld); check("R8 claimed edges ignored", v, 8'h00);
        rd(8'd1, v, vld); check("R8 claimed pins read 0", v, 8'hB0);

        // R9: bank disable
        wr(8'd5, 8'h00);
        wr(8'd0, 8'h00);
        check("R9 enabled bank drives", pad_oe, 8'hFF);
        wr(8'd6, 8'h00);
        check("R9 disabled bank releases", pad_oe, 8'h00);
        rd(8'd1, v, vld); check("R9 disabled bank reads 0", v, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule